// File: doc/BRIEF.md
# LCD Sync and Data-Enable Timing Generator

This block produces the raster timing for a 320x240 TFT panel that is fed through a parallel pixel port. It counts pixel-port clock ticks and drives active-low horizontal and vertical sync pulses. It also drives a data-enable window that marks where the active pixels of each line sit, and the line, pixel and visible-row coordinates that a pixel source uses to fetch data. One pixel can take one, two or three port clocks, depending on how the pixel is carried over the port. Every horizontal interval scales with that clocks-per-pixel setting. A second parameter, the packing-pipeline correction, moves the first valid pixel later.

Colour formatting, pixel storage and panel register setup live elsewhere. A synchronous enable starts the raster from frame start. While the enable is low, the raster is parked and both syncs stay inactive. The data-enable window is open on every one of the 244 lines. Two lines of data are fetched ahead of the 240 visible lines and two follow them. A separate qualifier marks the visible part.

Top module: `lcd_sync_gen`

## Requirements
- R1: While `en` is low (sampled on a clock edge), from the next clock onward `hsync_n` and `vsync_n` are 1, `de` and `vis_de` are 0, and `line_idx`, `pix_idx` and `row_idx` are 0; the same holds during reset.
- R2: With `en` held high, `hsync_n` falls once every 336*CPP clocks.
- R3: `hsync_n` is 0 for the first 2*CPP clocks of each line, where clock 0 of a line is the clock on which `hsync_n` falls, and is 1 for the rest of the line.
- R4: `de` is 1 for exactly 320*CPP consecutive clocks per line, starting at line clock 7*CPP+COR, where COR is 0, 3 or 5 for CPP 1, 2 or 3. `de` is never 1 while `hsync_n` is 0.
- R5: During `de`, `pix_idx` starts at 0 and counts up by one every CPP clocks, up to 319; outside `de` it is 0.
- R6: `line_idx` counts lines 0 to 243 and wraps to 0, so a frame lasts 244*336*CPP clocks and `vsync_n` falls once per frame.
- R7: `vsync_n` is 0 for 2*CPP clocks starting on the same clock as the `hsync_n` fall of line 0, and is 1 on all other clocks.
- R8: `vis_de` equals `de` on lines 2 to 241 and is 0 on lines 0, 1, 242 and 243; on lines 2 to 241, `row_idx` is `line_idx`-2 while `vis_de` is 1, and `row_idx` is 0 otherwise.
- R9: On the first clock after an edge that samples `en` high while the block is stopped, `hsync_n` and `vsync_n` are both 0 and `line_idx` is 0, even if the previous run was cut off mid-frame.
- R10: `de` opens on all 244 lines, the blanking lines included, with the same window as the visible lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous run enable; low parks the raster at frame start |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data-enable window, open on all 244 lines |
| vis_de | output | 1 | Data enable limited to the 240 visible lines |
| line_idx | output | 8 | Raster line number, 0 to 243 |
| pix_idx | output | 9 | Pixel number in the window, 0 to 319, 0 outside it |
| row_idx | output | 8 | Visible row number, 0 to 239, 0 outside `vis_de` |

## Verification
The hardest case to reach from the ports is the wrap of the line counter from 243 back to 0 at full timing. With two clocks per pixel, a frame takes close to 164,000 clocks. A second `vsync_n` fall is therefore seen only after the bench has run a full frame without a gap. The stimulus first cuts a run off partway through a line's data window, which exercises the restart path. It then holds the enable high for one whole frame plus two lines. A per-clock scoreboard compares every output against the expected raster over that span. Alongside it, run-length counters measure the line period, the frame period and the length of the data window.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  // Packing-pipeline correction in clocks for a given clocks-per-pixel mode.
  function automatic int unsigned pipe_cor_for(input int unsigned cpp);
    case (cpp)
      1:       return 0;
      2:       return 3;
      default: return 5;
    endcase
  endfunction

  // Horizontal window flags produced by the line counter.
  typedef struct packed {
    logic hs_win;
    logic vs_win;
    logic act_win;
  } lcdt_hwin_t;
endpackage

// File: rtl/lcdt_hcount.sv
module lcdt_hcount
  import lcdt_pkg::*;
#(
  parameter int unsigned HT   = 672,
  parameter int unsigned HSW  = 4,
  parameter int unsigned VSW  = 4,
  parameter int unsigned HST  = 17,
  parameter int unsigned HACT = 640,
  parameter int unsigned HW   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  output logic [HW-1:0] h_cnt,
  output logic          line_end,
  output lcdt_hwin_t    win
);
  localparam logic [HW-1:0] H_LAST = HW'(HT - 1);
  localparam logic [HW-1:0] H_HS   = HW'(HSW);
  localparam logic [HW-1:0] H_VS   = HW'(VSW);
  localparam logic [HW-1:0] H_ON   = HW'(HST);
  localparam logic [HW-1:0] H_OFF  = HW'(HST + HACT);

  logic [HW-1:0] h_q, h_d;

  always_comb begin
    h_d = h_q;
    if (clr)       h_d = '0;
    else if (run)  h_d = (h_q == H_LAST) ? '0 : h_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_q <= '0;
    else        h_q <= h_d;
  end

  assign h_cnt       = h_q;
  assign line_end    = run && (h_q == H_LAST);
  assign win.hs_win  = (h_q < H_HS);
  assign win.vs_win  = (h_q < H_VS);
  assign win.act_win = (h_q >= H_ON) && (h_q < H_OFF);

  p_hbound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    h_q <= H_LAST);
  p_hwrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && h_q == H_LAST) |=> (h_q == '0));
endmodule

// File: rtl/lcdt_vcount.sv
module lcdt_vcount #(
  parameter int unsigned VT   = 244,
  parameter int unsigned VTOP = 2,
  parameter int unsigned VVIS = 240,
  parameter int unsigned VW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [VW-1:0] v_cnt,
  output logic          top_line,
  output logic          vis_line
);
  localparam logic [VW-1:0] V_LAST  = VW'(VT - 1);
  localparam logic [VW-1:0] V_FIRST = VW'(VTOP);
  localparam logic [VW-1:0] V_END   = VW'(VTOP + VVIS);

  logic [VW-1:0] v_q, v_d;

  always_comb begin
    v_d = v_q;
    if (clr)      v_d = '0;
    else if (adv) v_d = (v_q == V_LAST) ? '0 : v_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  assign v_cnt    = v_q;
  assign top_line = (v_q == '0);
  assign vis_line = (v_q >= V_FIRST) && (v_q < V_END);

  p_vbound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    v_q <= V_LAST);
  p_vwrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && v_q == V_LAST) |=> (v_q == '0));
endmodule

// File: rtl/lcdt_pixcount.sv
module lcdt_pixcount #(
  parameter int unsigned CPP = 2,
  parameter int unsigned PW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          de_in,
  output logic [PW-1:0] pix
);
  localparam int unsigned SW = $clog2(CPP + 1);
  localparam logic [SW-1:0] PH_LAST = SW'(CPP - 1);

  logic [SW-1:0] ph_q, ph_d;
  logic [PW-1:0] pix_q, pix_d;

  always_comb begin
    ph_d  = ph_q;
    pix_d = pix_q;
    if (!de_in) begin
      ph_d  = '0;
      pix_d = '0;
    end else if (ph_q == PH_LAST) begin
      ph_d  = '0;
      pix_d = pix_q + 1'b1;
    end else begin
      ph_d  = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      pix_q <= '0;
    end else begin
      ph_q  <= ph_d;
      pix_q <= pix_d;
    end
  end

  assign pix = de_in ? pix_q : '0;

  p_phase_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= PH_LAST);
  p_pix_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (de_in && ph_q == PH_LAST) |=> (!de_in || pix_q == PW'($past(pix_q) + 1'b1)));
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcdt_pkg::*;
#(
  parameter int unsigned CPP          = 2,
  parameter int unsigned PIPE_COR     = pipe_cor_for(CPP),
  parameter int unsigned H_TOTAL_PIX  = 336,
  parameter int unsigned H_SYNC_PIX   = 2,
  parameter int unsigned H_LEAD_PIX   = 7,
  parameter int unsigned H_ACTIVE_PIX = 320,
  parameter int unsigned V_VISIBLE    = 240,
  parameter int unsigned V_BLANK      = 4,
  localparam int unsigned VT = V_VISIBLE + V_BLANK,
  localparam int unsigned VW = $clog2(VT),
  localparam int unsigned PW = $clog2(H_ACTIVE_PIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          de,
  output logic          vis_de,
  output logic [VW-1:0] line_idx,
  output logic [PW-1:0] pix_idx,
  output logic [VW-1:0] row_idx
);
  localparam int unsigned HT   = H_TOTAL_PIX * CPP;
  localparam int unsigned HSW  = H_SYNC_PIX * CPP;
  localparam int unsigned VSW  = 2 * CPP;
  localparam int unsigned HST  = H_LEAD_PIX * CPP + PIPE_COR;
  localparam int unsigned HACT = H_ACTIVE_PIX * CPP;
  localparam int unsigned HW   = $clog2(HT);
  localparam int unsigned VTOP = V_BLANK / 2;

  logic          act_q, act_d;
  logic [HW-1:0] h_cnt;
  logic          line_end;
  lcdt_hwin_t    win;
  logic [VW-1:0] v_cnt;
  logic          top_line, vis_line;

  always_comb act_d = en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  lcdt_hcount #(.HT(HT), .HSW(HSW), .VSW(VSW), .HST(HST), .HACT(HACT), .HW(HW)) u_h (
    .clk(clk), .rst_n(rst_n), .clr(!en), .run(act_q),
    .h_cnt(h_cnt), .line_end(line_end), .win(win)
  );

  lcdt_vcount #(.VT(VT), .VTOP(VTOP), .VVIS(V_VISIBLE), .VW(VW)) u_v (
    .clk(clk), .rst_n(rst_n), .clr(!en), .adv(line_end),
    .v_cnt(v_cnt), .top_line(top_line), .vis_line(vis_line)
  );

  lcdt_pixcount #(.CPP(CPP), .PW(PW)) u_p (
    .clk(clk), .rst_n(rst_n), .de_in(de), .pix(pix_idx)
  );

  assign hsync_n  = !(act_q && win.hs_win);
  assign vsync_n  = !(act_q && top_line && win.vs_win);
  assign de       = act_q && win.act_win;
  assign vis_de   = de && vis_line;
  assign line_idx = v_cnt;
  assign row_idx  = vis_de ? VW'(v_cnt - VW'(VTOP)) : '0;

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (hsync_n && vsync_n && !de && line_idx == '0));
  p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !act_q) |=> (!hsync_n && !vsync_n && line_idx == '0));
  p_de_off_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> hsync_n);
  p_vs_in_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> !hsync_n);
  p_vis_in_de_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vis_de |-> de);
endmodule

// File: tb/tb_lcd_sync_gen.sv
`timescale 1ns/1ps
module tb_lcd_sync_gen;
  localparam int CPP = 2, COR = 3;
  localparam int HT = 336*CPP, HSW = 2*CPP, VSW = 2*CPP;
  localparam int HST = 7*CPP + COR, HACT = 320*CPP;
  localparam int VT = 244, VTOP = 2, VVIS = 240;

  logic clk = 1'b0;
  logic rst_n, en;
  logic hsync_n, vsync_n, de, vis_de;
  logic [7:0] line_idx, row_idx;
  logic [8:0] pix_idx;

  always #2.5 clk = ~clk;

  lcd_sync_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .de(de), .vis_de(vis_de), .line_idx(line_idx), .pix_idx(pix_idx), .row_idx(row_idx)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  typedef struct {bit act; bit hs; bit vs; bit de; bit vde; int line; int pix; int row;} exp_t;
  exp_t q[$];

  // Expected raster from the requirements
  bit m_act;
  int m_hc, m_vc;

  task automatic push_expected();
    exp_t e;
    e.act  = m_act;
    e.hs   = !(m_act && m_hc < HSW);
    e.vs   = !(m_act && m_vc == 0 && m_hc < VSW);
    e.de   = m_act && m_hc >= HST && m_hc < HST + HACT;
    e.pix  = e.de ? (m_hc - HST) / CPP : 0;
    e.vde  = e.de && m_vc >= VTOP && m_vc < VTOP + VVIS;
    e.row  = e.vde ? m_vc - VTOP : 0;
    e.line = m_vc;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (!rst_n || !en) begin
      m_act = 0; m_hc = 0; m_vc = 0;
    end else if (!m_act) begin
      m_act = 1;
    end else begin
      m_hc++;
      if (m_hc == HT) begin
        m_hc = 0; m_vc++;
        if (m_vc == VT) m_vc = 0;
      end
    end
    push_expected();
  end

  // Monitor: scoreboard compare plus run-length measurements
  int cyc = 0, last_hf = 0, last_vf = 0, de_run = 0;
  bit hf_ok = 0, vf_ok = 0, prev_hs = 1, prev_vs = 1, prev_de = 0;

  always @(negedge clk) begin
    exp_t e;
    if (!done && q.size() > 0) begin
      e = q.pop_front();
      cyc++;
      chk(hsync_n == e.hs, e.act ? "R3" : "R1", "hsync_n", hsync_n, e.hs);
      chk(vsync_n == e.vs, e.act ? "R7" : "R1", "vsync_n", vsync_n, e.vs);
      chk(de == e.de, e.act ? ((e.line < VTOP || e.line >= VTOP+VVIS) ? "R10" : "R4") : "R1",
          "de", de, e.de);
      chk(vis_de == e.vde, e.act ? "R8" : "R1", "vis_de", vis_de, e.vde);
      chk(int'(row_idx) == e.row, e.act ? "R8" : "R1", "row_idx", row_idx, e.row);
      chk(int'(line_idx) == e.line, e.act ? "R6" : "R1", "line_idx", line_idx, e.line);
      chk(int'(pix_idx) == e.pix, e.act ? "R5" : "R1", "pix_idx", pix_idx, e.pix);
      if (!e.act) begin
        hf_ok = 0; vf_ok = 0; de_run = 0;
      end else begin
        if (prev_hs && !hsync_n) begin
          if (hf_ok) chk(cyc - last_hf == HT, "R2", "line period", cyc - last_hf, HT);
          last_hf = cyc; hf_ok = 1;
        end
        if (prev_vs && !vsync_n) begin
          if (vf_ok) chk(cyc - last_vf == HT*VT, "R6", "frame period", cyc - last_vf, HT*VT);
          last_vf = cyc; vf_ok = 1;
        end
        if (de) de_run++;
        if (prev_de && !de) begin
          chk(de_run == HACT, (e.line < VTOP || e.line >= VTOP+VVIS) ? "R10" : "R4",
              "de run length", de_run, HACT);
          de_run = 0;
        end
      end
      prev_hs = hsync_n; prev_vs = vsync_n; prev_de = de;
    end
  end

  initial begin
    rst_n = 0; en = 0;
    repeat (4) @(negedge clk);
    chk(hsync_n && vsync_n && !de && !vis_de, "R1", "reset sync/de idle",
        {hsync_n, vsync_n, de, vis_de}, 4'b1100);
    chk(line_idx == 0 && pix_idx == 0 && row_idx == 0, "R1", "reset coords",
        line_idx + pix_idx + row_idx, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    en = 1;
    @(negedge clk);
    chk(!hsync_n && !vsync_n && line_idx == 0, "R9", "first clock after enable",
        {hsync_n, vsync_n}, 0);
    repeat (2100) @(negedge clk);
    chk(de == 1 && line_idx == 3, "R4", "inside window before cut", {de, line_idx}, {1'b1, 8'd3});
    en = 0;
    repeat (20) @(negedge clk);
    chk(hsync_n && vsync_n && !de && line_idx == 0 && pix_idx == 0, "R1", "idle after disable",
        {hsync_n, vsync_n, de}, 3'b110);
    en = 1;
    @(negedge clk);
    chk(!hsync_n && !vsync_n && line_idx == 0 && pix_idx == 0, "R9", "restart after mid-line cut",
        {hsync_n, vsync_n}, 0);
    repeat (VT*HT + 2*HT + 50) @(negedge clk);
    chk(line_idx == 2, "R6", "line after one frame plus two lines", line_idx, 2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule